// File: doc/BRIEF.md
# Transceiver Channel Reset Sequencer

This block brings one serial transceiver channel out of reset. The channel has a transmit path and a receive path, and its receive clock-data-recovery loop is steered by hand rather than by its own lock detector. The block holds the transmit PLL powered down for a minimum time after power-on. It waits for the transmit PLL to report lock and then frees the transmit digital logic. It waits for the reconfiguration controller to go idle, then frees the receive analog front end. The recovery loop first trains on the reference clock. After the receive PLL reports lock and a fixed training time has passed, the block switches the loop over to the incoming data. A final settling time follows, and only then is the receive digital logic released.

All minimum times are given in nanoseconds and converted to clock cycles from a clock-frequency parameter. The conversion rounds up, so no interval is ever shorter than asked. The three status inputs may come from other clock domains, so each one passes through a parameterised synchronizer. If the transmit PLL loses lock at any point after lock was first seen, the block returns every output to its power-on value and starts the whole sequence again.

Top module: `xcvr_chan_rst_seq`

## Requirements
- R1: While `arst` is high the outputs read pll_pwrdn=1, tx_dig_rst=1, rx_ana_rst=1, rx_dig_rst=1, cdr_lock_ref=1, cdr_lock_data=0. After `arst` falls, `pll_pwrdn` falls on the PD_CYC-th rising edge, where PD_CYC = ceil(PWRDN_NS*CLK_HZ/1e9). PD_CYC is 125 at the default values.
- R2: While `pll_pwrdn` is high, all other outputs keep the values listed in R1.
- R3: `tx_dig_rst` stays high until `tx_pll_lock` has been seen high after `pll_pwrdn` fell. It then falls on the (SYNC_STAGES+1)-th rising edge after `tx_pll_lock` rises. If `tx_pll_lock` is already high, it falls on the first edge after `pll_pwrdn` falls.
- R4: `rx_ana_rst` stays high while `reconfig_busy` is high. It falls SYNC_STAGES+1+GAP_CYCLES edges after `reconfig_busy` falls. If `reconfig_busy` is already low, it falls GAP_CYCLES+1 edges after `tx_dig_rst` falls.
- R5: After `rx_ana_rst` falls, `cdr_lock_ref` stays 1 and `cdr_lock_data` stays 0 until the receive PLL lock has been seen.
- R6: `cdr_lock_ref` falls and `cdr_lock_data` rises on the same edge, REF_CYC edges after the receive PLL lock is seen. That is SYNC_STAGES+1+REF_CYC edges after `rx_pll_lock` rises, or REF_CYC+1 edges after `rx_ana_rst` falls if the lock is already high. REF_CYC is 1875 at the defaults.
- R7: Exactly one of `cdr_lock_ref` and `cdr_lock_data` is high at every moment.
- R8: `rx_dig_rst` falls DATA_CYC edges after the switch to data lock (500 at the defaults). It is the last output released, so when it falls all other resets and `pll_pwrdn` are already low.
- R9: If `tx_pll_lock` falls at any time after `tx_dig_rst` was released, all outputs return to the R1 values on the (SYNC_STAGES+1)-th edge. The sequence then restarts, and `pll_pwrdn` falls PD_CYC edges later.
- R10: Every timed interval lasts exactly its rounded-up cycle count, and that count times the clock period is never shorter than the nanosecond minimum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sequencer clock |
| arst | input | 1 | Asynchronous power-on reset, active high |
| tx_pll_lock | input | 1 | Transmit PLL lock status, asynchronous |
| rx_pll_lock | input | 1 | Receive PLL lock status, asynchronous |
| reconfig_busy | input | 1 | Reconfiguration controller busy, asynchronous |
| pll_pwrdn | output | 1 | Transmit PLL power-down |
| tx_dig_rst | output | 1 | Transmit digital reset |
| rx_ana_rst | output | 1 | Receive analog reset |
| rx_dig_rst | output | 1 | Receive digital reset |
| cdr_lock_ref | output | 1 | Recovery loop trains on the reference clock |
| cdr_lock_data | output | 1 | Recovery loop tracks the incoming data |

## Verification
A change on a status input reaches the outputs on the (SYNC_STAGES+1)-th rising edge: one edge per synchronizer stage plus the state and output register. A timed interval adds exactly its cycle count, counted from the edge that entered it. The bench drives each stimulus just after a falling edge and then counts falling edges until the watched output flips. It compares that count with the latency computed from R1 to R10 and the bench's own ceiling conversion. It also compares the full output pattern with the expected one at each step, so an early or late transition on any other output is caught as well.

// File: rtl/xcrs_pkg.sv
package xcrs_pkg;

   typedef enum logic [2:0] {
      ST_PWRDN    = 3'd0,
      ST_TXLOCK   = 3'd1,
      ST_BUSY     = 3'd2,
      ST_GAP      = 3'd3,
      ST_RXLOCK   = 3'd4,
      ST_REFHOLD  = 3'd5,
      ST_DATAHOLD = 3'd6,
      ST_RUN      = 3'd7
   } seq_st_t;

   typedef struct packed {
      logic pwrdn;
      logic tx_rst;
      logic rxa_rst;
      logic rxd_rst;
      logic lock_ref;
      logic lock_data;
   } ctl_t;

   localparam ctl_t CTL_SAFE = '{pwrdn: 1'b1, tx_rst: 1'b1, rxa_rst: 1'b1,
                                 rxd_rst: 1'b1, lock_ref: 1'b1, lock_data: 1'b0};

   // ceil(ns * hz / 1e9), never below one cycle
   function automatic int unsigned ns_to_cycles(input int unsigned hz, input int unsigned ns);
      longint unsigned prod;
      longint unsigned cyc;
      prod = longint'(ns) * longint'(hz);
      cyc  = (prod + 64'd999_999_999) / 64'd1_000_000_000;
      if (cyc == 64'd0) cyc = 64'd1;
      return cyc[31:0];
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   function automatic ctl_t ctl_for(input seq_st_t s);
      ctl_t c;
      c = CTL_SAFE;
      if (s != ST_PWRDN) c.pwrdn = 1'b0;
      if (s inside {ST_BUSY, ST_GAP, ST_RXLOCK, ST_REFHOLD, ST_DATAHOLD, ST_RUN}) c.tx_rst = 1'b0;
      if (s inside {ST_RXLOCK, ST_REFHOLD, ST_DATAHOLD, ST_RUN}) c.rxa_rst = 1'b0;
      if (s inside {ST_DATAHOLD, ST_RUN}) begin
         c.lock_ref  = 1'b0;
         c.lock_data = 1'b1;
      end
      if (s == ST_RUN) c.rxd_rst = 1'b0;
      return c;
   endfunction

endpackage

// File: rtl/xcrs_sync.sv
module xcrs_sync #(
   parameter int unsigned         WIDTH   = 3,
   parameter int unsigned         STAGES  = 2,
   parameter logic [WIDTH-1:0]    RST_VAL = '0
) (
   input  logic             clk,
   input  logic             arst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] stage [STAGES+1];
         assign stage[0] = d;
         for (genvar i = 1; i <= STAGES; i++) begin : g_stage
            always_ff @(posedge clk or posedge arst) begin
               if (arst) stage[i] <= RST_VAL;
               else      stage[i] <= stage[i-1];
            end
         end
         assign q = stage[STAGES];
      end
   endgenerate

endmodule

// File: rtl/xcrs_interval_timer.sv
module xcrs_interval_timer #(
   parameter int unsigned W         = 11,
   parameter int unsigned RST_COUNT = 0
) (
   input  logic         clk,
   input  logic         arst,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         expired
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or posedge arst) begin
      if (arst)            cnt <= W'(RST_COUNT);
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign expired = (cnt == '0);

   AST_TMR_COUNTS_DOWN: assert property (@(posedge clk) disable iff (arst)
      (!load && !expired) |=> (cnt == $past(cnt) - 1'b1)); // R10

   AST_TMR_HOLDS_ZERO: assert property (@(posedge clk) disable iff (arst)
      (!load && expired) |=> expired); // R10

endmodule

// File: rtl/xcvr_chan_rst_seq.sv
module xcvr_chan_rst_seq #(
   parameter int unsigned CLK_HZ         = 125_000_000,
   parameter int unsigned PWRDN_NS       = 1000,
   parameter int unsigned REF_TRAIN_NS   = 15000,
   parameter int unsigned DATA_SETTLE_NS = 4000,
   parameter int unsigned GAP_CYCLES     = 2,
   parameter int unsigned SYNC_STAGES    = 2
) (
   input  logic clk,
   input  logic arst,
   input  logic tx_pll_lock,
   input  logic rx_pll_lock,
   input  logic reconfig_busy,
   output logic pll_pwrdn,
   output logic tx_dig_rst,
   output logic rx_ana_rst,
   output logic rx_dig_rst,
   output logic cdr_lock_ref,
   output logic cdr_lock_data
);
   import xcrs_pkg::*;

   localparam int unsigned PD_CYC   = ns_to_cycles(CLK_HZ, PWRDN_NS);
   localparam int unsigned REF_CYC  = ns_to_cycles(CLK_HZ, REF_TRAIN_NS);
   localparam int unsigned DATA_CYC = ns_to_cycles(CLK_HZ, DATA_SETTLE_NS);
   localparam int unsigned MAX_CYC  = max2(max2(PD_CYC, REF_CYC), max2(DATA_CYC, GAP_CYCLES));
   localparam int unsigned TW       = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

   generate
      if (CLK_HZ == 0) begin : g_chk_hz
         $error("CLK_HZ must be non-zero");
      end
      if (GAP_CYCLES < 1) begin : g_chk_gap
         $error("GAP_CYCLES must be at least one");
      end
      if (SYNC_STAGES > 4) begin : g_chk_sync
         $error("SYNC_STAGES above four is not supported");
      end
   endgenerate

   // status synchronizers: {busy, rx lock, tx lock}; busy resets to "busy"
   logic [2:0] stat_s;
   logic       txl_s, rxl_s, busy_s;

   xcrs_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk  (clk),
      .arst (arst),
      .d    ({reconfig_busy, rx_pll_lock, tx_pll_lock}),
      .q    (stat_s)
   );
   assign txl_s  = stat_s[0];
   assign rxl_s  = stat_s[1];
   assign busy_s = stat_s[2];

   // sequence state
   seq_st_t      st, nxt;
   logic         tmr_done, tmr_load, tx_armed;
   logic [TW-1:0] tmr_val;

   xcrs_interval_timer #(.W(TW), .RST_COUNT(PD_CYC - 1)) u_tmr (
      .clk      (clk),
      .arst     (arst),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_done)
   );

   assign tx_armed = (st != ST_PWRDN) && (st != ST_TXLOCK);

   always_comb begin
      nxt = st;
      unique case (st)
         ST_PWRDN:    if (tmr_done) nxt = ST_TXLOCK;
         ST_TXLOCK:   if (txl_s)    nxt = ST_BUSY;
         ST_BUSY:     if (!busy_s)  nxt = ST_GAP;
         ST_GAP:      if (tmr_done) nxt = ST_RXLOCK;
         ST_RXLOCK:   if (rxl_s)    nxt = ST_REFHOLD;
         ST_REFHOLD:  if (tmr_done) nxt = ST_DATAHOLD;
         ST_DATAHOLD: if (tmr_done) nxt = ST_RUN;
         ST_RUN:      nxt = ST_RUN;
         default:     nxt = ST_PWRDN;
      endcase
      if (tx_armed && !txl_s) nxt = ST_PWRDN;
   end

   assign tmr_load = (nxt != st);

   always_comb begin
      unique case (nxt)
         ST_PWRDN:    tmr_val = TW'(PD_CYC - 1);
         ST_GAP:      tmr_val = TW'(GAP_CYCLES - 1);
         ST_REFHOLD:  tmr_val = TW'(REF_CYC - 1);
         ST_DATAHOLD: tmr_val = TW'(DATA_CYC - 1);
         default:     tmr_val = '0;
      endcase
   end

   // state and outputs registered together from the next state
   ctl_t ctl_q;

   always_ff @(posedge clk or posedge arst) begin
      if (arst) begin
         st    <= ST_PWRDN;
         ctl_q <= CTL_SAFE;
      end else begin
         st    <= nxt;
         ctl_q <= ctl_for(nxt);
      end
   end

   assign pll_pwrdn     = ctl_q.pwrdn;
   assign tx_dig_rst    = ctl_q.tx_rst;
   assign rx_ana_rst    = ctl_q.rxa_rst;
   assign rx_dig_rst    = ctl_q.rxd_rst;
   assign cdr_lock_ref  = ctl_q.lock_ref;
   assign cdr_lock_data = ctl_q.lock_data;

   AST_PWRDN_HOLDS_ALL: assert property (@(posedge clk) disable iff (arst)
      pll_pwrdn |-> (tx_dig_rst && rx_ana_rst && rx_dig_rst && cdr_lock_ref && !cdr_lock_data)); // R2

   AST_TX_NEEDS_LOCK: assert property (@(posedge clk) disable iff (arst)
      $fell(tx_dig_rst) |-> $past(txl_s)); // R3

   AST_RXA_AFTER_TX: assert property (@(posedge clk) disable iff (arst)
      !rx_ana_rst |-> !tx_dig_rst); // R4

   AST_RXA_NEEDS_IDLE: assert property (@(posedge clk) disable iff (arst)
      $fell(rx_ana_rst) |-> !$past(busy_s, 1 + GAP_CYCLES)); // R4

   AST_CDR_ONE_MODE: assert property (@(posedge clk) disable iff (arst)
      $onehot({cdr_lock_ref, cdr_lock_data})); // R7

   AST_DATA_NEEDS_RXLOCK: assert property (@(posedge clk) disable iff (arst)
      $rose(cdr_lock_data) |-> !rx_ana_rst); // R5

   AST_RXD_LAST: assert property (@(posedge clk) disable iff (arst)
      !rx_dig_rst |-> (!pll_pwrdn && !tx_dig_rst && !rx_ana_rst && cdr_lock_data)); // R8

   AST_TXLOSS_RESTART: assert property (@(posedge clk) disable iff (arst)
      (tx_armed && !txl_s) |=> (pll_pwrdn && tx_dig_rst && rx_ana_rst && rx_dig_rst)); // R9

endmodule

// File: tb/xcvr_chan_rst_seq_test.sv
`timescale 1ns/1ps
module xcvr_chan_rst_seq_test;

   localparam int unsigned CLK_HZ   = 125_000_000;
   localparam int unsigned PD_NS    = 1000;
   localparam int unsigned REF_NS   = 15000;
   localparam int unsigned DATA_NS  = 4000;
   localparam int          GAP      = 2;
   localparam int          SYNC     = 2;

   logic clk = 1'b0;
   logic arst = 1'b1;
   logic txl = 1'b0, rxl = 1'b0, busy = 1'b1;
   logic pll_pwrdn, tx_dig_rst, rx_ana_rst, rx_dig_rst, cdr_lock_ref, cdr_lock_data;

   int total = 0;
   int bad = 0;
   int cyc = 0;

   always #4 clk = ~clk;

   xcvr_chan_rst_seq uut (
      .clk           (clk),
      .arst          (arst),
      .tx_pll_lock   (txl),
      .rx_pll_lock   (rxl),
      .reconfig_busy (busy),
      .pll_pwrdn     (pll_pwrdn),
      .tx_dig_rst    (tx_dig_rst),
      .rx_ana_rst    (rx_ana_rst),
      .rx_dig_rst    (rx_dig_rst),
      .cdr_lock_ref  (cdr_lock_ref),
      .cdr_lock_data (cdr_lock_data)
   );

   function automatic int ceil_cyc(input int unsigned ns);
      longint unsigned p;
      p = longint'(ns) * longint'(CLK_HZ);
      return int'((p + 64'd999_999_999) / 64'd1_000_000_000);
   endfunction

   function automatic bit [5:0] outs();
      return {pll_pwrdn, tx_dig_rst, rx_ana_rst, rx_dig_rst, cdr_lock_ref, cdr_lock_data};
   endfunction

   function automatic bit pick(input int idx);
      bit [5:0] o;
      o = outs();
      return o[5-idx];
   endfunction

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         total++;
         bad++;
         $display("FAIL watchdog (R1..R10 flow) actual=%0d expected<=%0d", cyc, 150000);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_eq(input string req, input int act, input int exp);
      chk(act == exp, req, act, exp);
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // counts falling edges until output idx reaches tgt; called right after a falling edge
   task automatic lat(input int idx, input bit tgt, input int maxc, output int n);
      n = 0;
      while (pick(idx) != tgt && n < maxc) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic restart_check(input int d);
      int n;
      step(d);
      txl = 1'b0;
      lat(0, 1'b1, 20, n);
      chk_eq("R9 restart latency", n, SYNC + 1);
      chk_eq("R9 outputs back to safe", int'(outs()), int'(6'b111110));
      lat(0, 1'b0, ceil_cyc(PD_NS) + 20, n);
      chk_eq("R9 power-down repeated", n, ceil_cyc(PD_NS));
      step(5);
      chk_eq("R9 tx reset waits for lock", int'(outs()), int'(6'b011110));
   endtask

   task automatic run_seq(input bit tx_early, input bit busy_low, input bit rx_early,
                          input int rs_phase, input int dmax);
      int n, d, half;
      @(negedge clk);
      arst = 1'b1;
      txl  = tx_early;
      rxl  = rx_early;
      busy = !busy_low;
      step(3);
      chk_eq("R1 reset values", int'(outs()), int'(6'b111110));
      arst = 1'b0;
      half = ceil_cyc(PD_NS) / 2;
      step(half);
      chk_eq("R2 held during power-down", int'(outs()), int'(6'b111110));
      lat(0, 1'b0, ceil_cyc(PD_NS) + 20, n);
      chk_eq("R1 power-down length", n + half, ceil_cyc(PD_NS));
      chk((longint'(n + half) * 64'd1_000_000_000) >= (longint'(PD_NS) * longint'(CLK_HZ)),
          "R10 power-down not short", n + half, ceil_cyc(PD_NS));
      chk_eq("R2 pattern at release", int'(outs()), int'(6'b011110));
      if (tx_early) begin
         lat(1, 1'b0, 20, n);
         chk_eq("R3 early lock latency", n, 1);
      end else begin
         d = 1 + int'($urandom % dmax);
         step(d);
         chk_eq("R3 tx reset held without lock", int'(outs()), int'(6'b011110));
         txl = 1'b1;
         lat(1, 1'b0, 20, n);
         chk_eq("R3 lock latency", n, SYNC + 1);
      end
      if (busy_low) begin
         lat(2, 1'b0, 20, n);
         chk_eq("R4 idle gap latency", n, GAP + 1);
      end else begin
         d = 1 + int'($urandom % dmax);
         step(d);
         chk_eq("R4 analog reset held while busy", int'(outs()), int'(6'b001110));
         busy = 1'b0;
         lat(2, 1'b0, 20, n);
         chk_eq("R4 busy release latency", n, SYNC + 1 + GAP);
      end
      chk_eq("R5 ref lock after analog release", int'(outs()), int'(6'b000110));
      if (rx_early) begin
         lat(4, 1'b0, ceil_cyc(REF_NS) + 50, n);
         chk_eq("R6 early rx lock training time", n, ceil_cyc(REF_NS) + 1);
      end else begin
         d = 1 + int'($urandom % dmax);
         step(d);
         chk_eq("R5 ref lock held without rx lock", int'(outs()), int'(6'b000110));
         rxl = 1'b1;
         lat(4, 1'b0, ceil_cyc(REF_NS) + 50, n);
         chk_eq("R6 training time", n, SYNC + 1 + ceil_cyc(REF_NS));
      end
      chk_eq("R7 switch on one edge", int'(outs()), int'(6'b000101));
      if (rs_phase == 1) begin
         restart_check(1 + int'($urandom % dmax));
         return;
      end
      lat(3, 1'b0, ceil_cyc(DATA_NS) + 50, n);
      chk_eq("R8 data settle time", n, ceil_cyc(DATA_NS));
      chk_eq("R8 rx digital released last", int'(outs()), int'(6'b000001));
      if (rs_phase == 2) restart_check(1 + int'($urandom % dmax));
   endtask

   initial begin
      void'($urandom(32'h5EED_0C21));
      run_seq(1'b0, 1'b0, 1'b0, 0, 20);
      run_seq(1'b1, 1'b1, 1'b1, 0, 20);
      run_seq(1'b0, 1'b1, 1'b0, 1, 20);
      run_seq(1'b1, 1'b0, 1'b1, 2, 20);
      for (int k = 0; k < 6; k++) begin
         run_seq(1'($urandom), 1'($urandom), 1'($urandom), int'($urandom % 3), 40);
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule